// File: doc/BRIEF.md
# Serial Character Transmit Framer

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. Software or an upstream engine writes a character into a one-entry holding register with a load strobe. When the shift stage is free, the character moves into it. It then leaves as a low start bit, followed by 5 to 8 data bits sent least significant bit first, followed by high stop bits. The line rests high between frames.

Timing comes from an external oversampling tick. It is a one-cycle enable, produced by a clock divider elsewhere. Every start bit and every data bit lasts a fixed number of ticks, seven by default. The stop interval is one bit long, or longer when the stop control is set. With the stop control set, 6-, 7- and 8-bit characters get two stop bits. 5-bit characters get one and a half stop bits, which is 11 ticks.

The character length code and the stop control are sampled when a character enters the shift stage, and they hold for the whole frame. Two flags report progress. One shows the holding register is free to accept a character. The other shows that no frame is in flight. When a character is already waiting at the end of the stop interval, its start bit follows with no idle time.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, `txLine` is 1, `holdEmpty` is 1 and `shiftEmpty` is 1.
- R2: `wordLen` selects the number of data bits: code 0 gives 5, code 1 gives 6, code 2 gives 7 and code 3 gives 8. Each frame is a low start bit, then data bit 0 first up to the last selected bit, then high stop bits.
- R3: The start bit and each data bit last exactly TICKS_PER_BIT (7) cycles in which `baudTick` is 1. When `baudTick` is 0, `txLine` does not change while a frame is in flight.
- R4: With `stopSel` = 0, the stop interval is high for 7 ticks, whatever the character length.
- R5: With `stopSel` = 1 and `wordLen` of 1, 2 or 3, the stop interval is high for 14 ticks.
- R6: With `stopSel` = 1 and `wordLen` = 0, the stop interval is high for 11 ticks, which is 1.5 bits rounded up.
- R7: A `holdLoad` pulse makes `holdEmpty` 0 from the next cycle. `holdEmpty` returns to 1 in the same edge that moves the character into the shift stage, which is the edge after the load when the line is idle.
- R8: `shiftEmpty` falls at that transfer edge and the start bit (`txLine` 0) appears at the same edge. `shiftEmpty` rises, with `txLine` high, at the edge that takes the last stop tick.
- R9: When a character is waiting at the last stop tick, that same edge starts its start bit. `shiftEmpty` stays 0 and `holdEmpty` returns to 1.
- R10: `wordLen` and `stopSel` are captured at the transfer edge. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle oversampling tick enable |
| holdData | input | 8 | Character to load; bits above the selected length are ignored |
| holdLoad | input | 1 | Writes `holdData` into the holding register |
| wordLen | input | 2 | Character length code (0..3 for 5..8 bits) |
| stopSel | input | 1 | 0 = one stop bit, 1 = long stop interval |
| txLine | output | 1 | Serial output, high when idle |
| holdEmpty | output | 1 | Holding register can accept a character |
| shiftEmpty | output | 1 | No frame in flight |

## Verification
A wrong tick or bit count inside the framer shows on `txLine` within one bit time of the miscount. Every bit interval therefore shows up as a run of samples taken once per tick, and each run is compared against a frame rebuilt from the data, the length code and the stop control. A stop length chosen from the wrong table shows at the end of the stop interval, as an early or late return of `shiftEmpty`, or as a premature start bit for a waiting character. A lost holding-register state shows within two cycles of a load, as a `holdEmpty` level that is wrong or a frame that never starts.

// File: rtl/uart_tx_framer_pkg.sv
package uart_tx_framer_pkg;

  localparam int CHAR_MAX = 8;
  localparam int CHAR_MIN = 5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } txState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic xfer;      // move holding register into shifter, capture config
    logic shift;     // advance to next data bit
    logic driveLow;  // start bit on the line
    logic driveData; // data bit on the line
  } txStrobe_t;

endpackage

// File: rtl/uart_tx_framer_ctrl.sv
module uart_tx_framer_ctrl
  import uart_tx_framer_pkg::*;
#(
  parameter int TICKS_PER_BIT = 7,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baudTick,
  input  logic             holdFull,
  input  logic [2:0]       cfgLastBit,
  input  logic [CNT_W-1:0] cfgStopLast,
  output txStrobe_t        strobe,
  output logic             shiftEmpty
);

  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(TICKS_PER_BIT - 1);

  txState_e         state, stateNext;
  logic [CNT_W-1:0] tickCnt;
  logic [2:0]       bitCnt;
  logic [CNT_W-1:0] tickLimit;
  logic             tickDone;

  assign tickLimit = (state == ST_STOP) ? cfgStopLast : BIT_LAST;
  assign tickDone  = baudTick && (tickCnt == tickLimit);

  always_comb begin
    stateNext        = state;
    strobe.xfer      = 1'b0;
    strobe.shift     = 1'b0;
    strobe.driveLow  = (state == ST_START);
    strobe.driveData = (state == ST_DATA);
    unique case (state)
      ST_IDLE: begin
        if (holdFull) begin
          strobe.xfer = 1'b1;
          stateNext   = ST_START;
        end
      end
      ST_START: begin
        if (tickDone) stateNext = ST_DATA;
      end
      ST_DATA: begin
        if (tickDone) begin
          strobe.shift = 1'b1;
          if (bitCnt == cfgLastBit) stateNext = ST_STOP;
        end
      end
      ST_STOP: begin
        if (tickDone) begin
          if (holdFull) begin
            strobe.xfer = 1'b1;
            stateNext   = ST_START;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      state <= stateNext;
      if (strobe.xfer || state == ST_IDLE) begin
        tickCnt <= '0;
      end else if (baudTick) begin
        tickCnt <= tickDone ? '0 : tickCnt + 1'b1;
      end
      if (state != ST_DATA) begin
        bitCnt <= '0;
      end else if (tickDone) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign shiftEmpty = (state == ST_IDLE);

endmodule

// File: rtl/uart_tx_framer_dp.sv
module uart_tx_framer_dp
  import uart_tx_framer_pkg::*;
#(
  parameter int TICKS_PER_BIT = 7,
  parameter int CNT_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CHAR_MAX-1:0] holdData,
  input  logic                holdLoad,
  input  logic [1:0]          wordLen,
  input  logic                stopSel,
  input  txStrobe_t           strobe,
  output logic                holdFull,
  output logic [2:0]          cfgLastBit,
  output logic [CNT_W-1:0]    cfgStopLast,
  output logic                txLine
);

  localparam int HALF_STOP = TICKS_PER_BIT + (TICKS_PER_BIT + 1) / 2;
  localparam logic [CNT_W-1:0] ONE_LAST  = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] TWO_LAST  = CNT_W'(2 * TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_STOP - 1);

  logic [CHAR_MAX-1:0] holdReg;
  logic [CHAR_MAX-1:0] shiftReg;
  logic [CNT_W-1:0]    stopLastSel;

  always_comb begin
    if (!stopSel)             stopLastSel = ONE_LAST;
    else if (wordLen == 2'd0) stopLastSel = HALF_LAST;
    else                      stopLastSel = TWO_LAST;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg     <= '0;
      holdFull    <= 1'b0;
      shiftReg    <= '0;
      cfgLastBit  <= 3'(CHAR_MAX - 1);
      cfgStopLast <= ONE_LAST;
    end else begin
      if (holdLoad) holdReg <= holdData;
      holdFull <= holdLoad | (holdFull & ~strobe.xfer);
      if (strobe.xfer) begin
        shiftReg    <= holdReg;
        cfgLastBit  <= 3'(CHAR_MIN - 1) + {1'b0, wordLen};
        cfgStopLast <= stopLastSel;
      end else if (strobe.shift) begin
        shiftReg <= {1'b0, shiftReg[CHAR_MAX-1:1]};
      end
    end
  end

  assign txLine = strobe.driveLow  ? 1'b0 :
                  strobe.driveData ? shiftReg[0] : 1'b1;

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_framer_pkg::*;
#(
  parameter int TICKS_PER_BIT = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic [7:0] holdData,
  input  logic       holdLoad,
  input  logic [1:0] wordLen,
  input  logic       stopSel,
  output logic       txLine,
  output logic       holdEmpty,
  output logic       shiftEmpty
);

  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT);

  txStrobe_t        strobe;
  logic             holdFull;
  logic [2:0]       cfgLastBit;
  logic [CNT_W-1:0] cfgStopLast;

  uart_tx_framer_ctrl #(.TICKS_PER_BIT(TICKS_PER_BIT), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .holdFull(holdFull),
    .cfgLastBit(cfgLastBit), .cfgStopLast(cfgStopLast),
    .strobe(strobe), .shiftEmpty(shiftEmpty)
  );

  uart_tx_framer_dp #(.TICKS_PER_BIT(TICKS_PER_BIT), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .holdData(holdData), .holdLoad(holdLoad),
    .wordLen(wordLen), .stopSel(stopSel), .strobe(strobe),
    .holdFull(holdFull), .cfgLastBit(cfgLastBit), .cfgStopLast(cfgStopLast),
    .txLine(txLine)
  );

  assign holdEmpty = ~holdFull;

endmodule

// File: rtl/uart_tx_framer_chk.sv
module uart_tx_framer_chk (
  input logic clk,
  input logic rstN,
  input logic baudTick,
  input logic holdLoad,
  input logic txLine,
  input logic holdEmpty,
  input logic shiftEmpty
);

  // R3: no tick, no line movement while a frame is in flight
  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!baudTick && !shiftEmpty) |=> $stable(txLine));

  // R7: a load fills the holding register
  a_r7_load_fills: assert property (@(posedge clk) disable iff (!rstN)
    holdLoad |=> !holdEmpty);

  // R7: the holding register only empties into a busy shifter
  a_r7_empty_on_xfer: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdEmpty) |-> !shiftEmpty);

  // R8: the idle line is high
  a_r8_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    shiftEmpty |-> txLine);

  // R8: a frame opens with the start bit
  a_r8_start_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shiftEmpty) |-> !txLine);

  // R9: a waiting character never leaves the shifter idle
  a_r9_no_idle_wait: assert property (@(posedge clk) disable iff (!rstN)
    (!holdEmpty && shiftEmpty) |=> !shiftEmpty);

endmodule

bind uart_tx_framer uart_tx_framer_chk chk_i (
  .clk(clk), .rstN(rstN), .baudTick(baudTick), .holdLoad(holdLoad),
  .txLine(txLine), .holdEmpty(holdEmpty), .shiftEmpty(shiftEmpty)
);

// File: tb/uart_tx_framer_tb_top.sv
module uart_tx_framer_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic [7:0] holdData = '0;
  logic       holdLoad = 1'b0;
  logic [1:0] wordLen = 2'd3;
  logic       stopSel = 1'b0;
  logic       txLine, holdEmpty, shiftEmpty;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_tx_framer dut_i (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .holdData(holdData),
    .holdLoad(holdLoad), .wordLen(wordLen), .stopSel(stopSel),
    .txLine(txLine), .holdEmpty(holdEmpty), .shiftEmpty(shiftEmpty)
  );

  // {data, wordLen, stopSel}
  localparam logic [10:0] VECS [6] = '{
    {8'hA5, 2'd3, 1'b0},
    {8'h3C, 2'd2, 1'b1},
    {8'h1B, 2'd0, 1'b1},
    {8'h16, 2'd0, 1'b0},
    {8'hD2, 2'd1, 1'b1},
    {8'hFF, 2'd3, 1'b1}
  };

  function automatic int stopTicks(input logic [1:0] wl, input logic ss);
    if (!ss) return 7;
    return (wl == 2'd0) ? 11 : 14;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic loadChar(input logic [7:0] d);
    @(negedge clk);
    holdData = d;
    holdLoad = 1'b1;
    @(negedge clk);
    holdLoad = 1'b0;
  endtask

  // One tick: sample the line level of the current tick interval, then
  // let the edge consume it; returns at the negedge after that edge.
  task automatic doTick(output logic lvl);
    @(negedge clk);
    baudTick = 1'b1;
    lvl = txLine;
    @(negedge clk);
    baudTick = 1'b0;
    @(negedge clk);
  endtask

  // Run the ticks of one frame (already transferred) and compare the line
  task automatic runFrame(input logic [7:0] d, input logic [1:0] wl,
                          input logic ss);
    int nBits = int'(wl) + 5;
    int stopT = stopTicks(wl, ss);
    int total = 7 + 7 * nBits + stopT;
    for (int i = 0; i < total; i++) begin
      logic lvl;
      logic exp;
      string tag;
      doTick(lvl);
      if (i < 7) begin
        exp = 1'b0; tag = "R2/R3 start";
      end else if (i < 7 + 7 * nBits) begin
        exp = d[(i - 7) / 7]; tag = "R2/R3 data";
      end else begin
        exp = 1'b1;
        tag = !ss ? "R4 stop" : (wl == 2'd0 ? "R6 stop" : "R5 stop");
      end
      check(tag, lvl, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 txLine", txLine, 1'b1);
    check("R1 holdEmpty", holdEmpty, 1'b1);
    check("R1 shiftEmpty", shiftEmpty, 1'b1);
    rstN = 1'b1;
    @(negedge clk);

    // Table-driven frames
    for (int v = 0; v < 6; v++) begin
      logic [7:0] d;
      logic [1:0] wl;
      logic ss;
      {d, wl, ss} = VECS[v];
      wordLen = wl;
      stopSel = ss;
      loadChar(d);
      check("R7 full after load", holdEmpty, 1'b0);
      @(negedge clk);
      check("R7 empty at transfer", holdEmpty, 1'b1);
      check("R8 busy at transfer", shiftEmpty, 1'b0);
      check("R8 start at transfer", txLine, 1'b0);
      runFrame(d, wl, ss);
      check("R8 idle after stop", shiftEmpty, 1'b1);
      check("R8 line high after stop", txLine, 1'b1);
    end

    // R3: no ticks, no progress
    wordLen = 2'd2; stopSel = 1'b0;
    loadChar(8'h55);
    @(negedge clk);
    repeat (20) @(negedge clk);
    check("R3 stall line", txLine, 1'b0);
    check("R3 stall busy", shiftEmpty, 1'b0);
    runFrame(8'h55, 2'd2, 1'b0);

    // R10: settings captured at transfer
    wordLen = 2'd3; stopSel = 1'b0;
    loadChar(8'h81);
    @(negedge clk);
    wordLen = 2'd0; stopSel = 1'b1;
    runFrame(8'h81, 2'd3, 1'b0);
    check("R10 idle after captured frame", shiftEmpty, 1'b1);

    // R9: back-to-back frames with no idle gap
    wordLen = 2'd0; stopSel = 1'b1;
    loadChar(8'h0D);
    @(negedge clk);
    loadChar(8'h12);
    check("R9 second char waiting", holdEmpty, 1'b0);
    runFrame(8'h0D, 2'd0, 1'b1);
    check("R9 no idle between frames", shiftEmpty, 1'b0);
    check("R9 holding emptied", holdEmpty, 1'b1);
    check("R9 start follows stop", txLine, 1'b0);
    runFrame(8'h12, 2'd0, 1'b1);
    check("R9 idle after pair", shiftEmpty, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule